// File: doc/BRIEF.md
# Saturating Up/Down Event Counter

A single counter field that hardware steps up or down through two request inputs. Each direction has its own step size, which is either a build-time constant or a runtime input. The count can wrap modulo 2^CNT_W, or it can be held inside an upper and a lower saturation bound. Each bound is disabled, fixed at build time, or taken from an input port. Two threshold flags compare in opposite directions. The "high" flag is set while the count is at or above its threshold. The "low" flag is set while the count is at or below its threshold.

Software reaches the field through a clear strobe and a write strobe with data. The saturation bounds are enforced on every value the register takes, including software writes and plain holds. If a runtime bound moves past the current count, the count is pulled back inside it on the next clock edge. In wrapping configurations, the overflow and underflow outputs flag, during the cycle itself, an update that is about to cross the top or the bottom of the range.

The default build enables both directions. It takes the step sizes, the saturation bounds and the thresholds from ports.

Top module: `evt_counter`

## Requirements
- R1: While `rst_n` is low, `count` is RST_VAL, which is 0 by default.
- R2: With `incr` high, `decr` low and no software strobe, the next `count` is `count + incr_step`, provided that value lies inside the enabled bounds.
- R3: With `decr` high, `incr` low and no software strobe, the next `count` is `count - decr_step`, provided that value lies inside the enabled bounds.
- R4: With `incr` and `decr` both high, the net value `count + incr_step - decr_step` is formed once, and saturation or wrapping is then applied to that result.
- R5: With upper saturation enabled, any candidate value above the upper bound becomes the bound. `overflow` stays low, even when the candidate exceeds 2^CNT_W - 1.
- R6: With lower saturation enabled, any candidate value below the lower bound becomes the bound. `underflow` stays low, even when the candidate is negative.
- R7: Bounds apply to every next value: software-written values, holds, and counts left outside by a moved runtime bound. If the lower bound exceeds the upper bound, the lower bound wins.
- R8: `sw_clr` has priority over `sw_we`, and both have priority over `incr`/`decr`. A clear loads 0, and a write loads `sw_wdata`, each subject to the bounds.
- R9: `thr_hi_flag` is high exactly while `count >= ` the high threshold. The threshold is taken from `thr_hi_in` or fixed, and defaults to 2^CNT_W - 1.
- R10: `thr_lo_flag` is high exactly while `count <= ` the low threshold. The threshold is taken from `thr_lo_in` or fixed, and defaults to 0.
- R11: With upper saturation disabled, a counting update whose value exceeds 2^CNT_W - 1 raises `overflow` in that same cycle, and the count wraps modulo 2^CNT_W.
- R12: With lower saturation disabled, a counting update whose value is below 0 raises `underflow` in that same cycle, and the count wraps modulo 2^CNT_W.
- R13: When a step size or threshold is configured as fixed, the matching input port has no effect on `count` or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| incr | input | 1 | Count-up request |
| decr | input | 1 | Count-down request |
| incr_step | input | STEP_W | Runtime up step |
| decr_step | input | STEP_W | Runtime down step |
| sat_hi_in | input | CNT_W | Runtime upper saturation bound |
| sat_lo_in | input | CNT_W | Runtime lower saturation bound |
| thr_hi_in | input | CNT_W | Runtime high threshold |
| thr_lo_in | input | CNT_W | Runtime low threshold |
| sw_clr | input | 1 | Software clear strobe |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | CNT_W | Software write data |
| count | output | CNT_W | Current count |
| thr_hi_flag | output | 1 | Count at or above high threshold |
| thr_lo_flag | output | 1 | Count at or below low threshold |
| overflow | output | 1 | Current update wraps past the top |
| underflow | output | 1 | Current update wraps past the bottom |

## Verification
Two collisions matter most. The first is a simultaneous up and down request; the second is a software write or clear landing together with a counting request. Random stimulus raises `incr` and `decr` independently, so both requests coincide in about a quarter of cycles. Software strobes are sprinkled among those cycles, and bound changes are occasionally made to invert (lower above upper). Directed cycles then push a net step exactly onto a bound and across the wrap point. A bench model predicts each next count from the priority and clamp rules, and each same-cycle wrap flag from the pre-edge count. A saturating instance and a wrapping, fixed-step instance are judged side by side.

// File: rtl/evc_pkg.sv
package evc_pkg;

   // Source of a step, bound or threshold value
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_FIXED = 2'd1,
      SRC_PORT  = 2'd2
   } src_e;

endpackage

// File: rtl/evc_src_sel.sv
module evc_src_sel #(
   parameter int            W     = 8,
   parameter evc_pkg::src_e SRC   = evc_pkg::SRC_PORT,
   parameter logic [W-1:0]  FIXED = '0,
   parameter logic [W-1:0]  DEFLT = '0
) (
   input  logic [W-1:0] port_val,
   output logic [W-1:0] val
);

   generate
      if (SRC == evc_pkg::SRC_PORT) begin : g_port
         assign val = port_val;
      end else if (SRC == evc_pkg::SRC_FIXED) begin : g_fixed
         logic unused_port;
         assign unused_port = ^port_val;
         assign val = FIXED;
      end else begin : g_default
         logic unused_port;
         assign unused_port = ^port_val;
         assign val = DEFLT;
      end
   endgenerate

endmodule

// File: rtl/evc_cmp.sv
module evc_cmp #(
   parameter int W        = 8,
   parameter bit AT_LEAST = 1'b1
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] limit,
   output logic         hit
);

   generate
      if (AT_LEAST) begin : g_ge
         assign hit = (value >= limit);
      end else begin : g_le
         assign hit = (value <= limit);
      end
   endgenerate

endmodule

// File: rtl/evc_next.sv
module evc_next #(
   parameter int CNT_W     = 8,
   parameter int STEP_W    = 4,
   parameter bit UP_EN     = 1'b1,
   parameter bit DN_EN     = 1'b1,
   parameter bit UP_SAT_ON = 1'b1,
   parameter bit DN_SAT_ON = 1'b1
) (
   input  logic [CNT_W-1:0]  count,
   input  logic              incr,
   input  logic              decr,
   input  logic [STEP_W-1:0] up_step,
   input  logic [STEP_W-1:0] dn_step,
   input  logic [CNT_W-1:0]  lim_hi,
   input  logic [CNT_W-1:0]  lim_lo,
   input  logic              sw_clr,
   input  logic              sw_we,
   input  logic [CNT_W-1:0]  sw_wdata,
   output logic [CNT_W-1:0]  nxt,
   output logic              ovf,
   output logic              udf
);

   localparam int EXT_W = CNT_W + 2;
   localparam int PAD_W = EXT_W - STEP_W;
   localparam logic signed [EXT_W-1:0] MAX_S = $signed({2'b00, {CNT_W{1'b1}}});

   logic signed [EXT_W-1:0] up_t;
   logic signed [EXT_W-1:0] dn_t;
   logic signed [EXT_W-1:0] cand;
   logic signed [EXT_W-1:0] clmp;
   logic signed [EXT_W-1:0] hi_s;
   logic signed [EXT_W-1:0] lo_s;
   logic                    sw_any;
   logic                    unused_hi_bits;
   logic                    unused_limits;

   assign hi_s   = $signed({2'b00, lim_hi});
   assign lo_s   = $signed({2'b00, lim_lo});
   assign sw_any = sw_clr | sw_we;

   generate
      if (UP_EN) begin : g_up
         assign up_t = incr ? $signed({{PAD_W{1'b0}}, up_step}) : '0;
      end else begin : g_no_up
         logic unused_up;
         assign unused_up = ^{incr, up_step};
         assign up_t = '0;
      end

      if (DN_EN) begin : g_dn
         assign dn_t = decr ? $signed({{PAD_W{1'b0}}, dn_step}) : '0;
      end else begin : g_no_dn
         logic unused_dn;
         assign unused_dn = ^{decr, dn_step};
         assign dn_t = '0;
      end
   endgenerate

   // candidate value: software first, then one net counting step
   always_comb begin
      if (sw_clr) begin
         cand = '0;
      end else if (sw_we) begin
         cand = $signed({2'b00, sw_wdata});
      end else begin
         cand = $signed({2'b00, count}) + up_t - dn_t;
      end
   end

   // clamp: upper first, lower last so the lower bound wins a conflict
   generate
      logic signed [EXT_W-1:0] after_hi;
      if (UP_SAT_ON) begin : g_hi_clamp
         assign after_hi = (cand > hi_s) ? hi_s : cand;
         assign ovf      = 1'b0;
      end else begin : g_hi_wrap
         assign after_hi = cand;
         assign ovf      = !sw_any && (cand > MAX_S);
      end

      if (DN_SAT_ON) begin : g_lo_clamp
         assign clmp = (after_hi < lo_s) ? lo_s : after_hi;
         assign udf  = 1'b0;
      end else begin : g_lo_wrap
         assign clmp = after_hi;
         assign udf  = !sw_any && (cand < 0);
      end
   endgenerate

   assign nxt            = clmp[CNT_W-1:0];
   assign unused_hi_bits = ^clmp[EXT_W-1:CNT_W];
   assign unused_limits  = ^{lim_hi, lim_lo};

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int                CNT_W       = 8,
   parameter int                STEP_W      = 4,
   parameter bit                UP_EN       = 1'b1,
   parameter bit                DN_EN       = 1'b1,
   parameter evc_pkg::src_e     UP_STEP_SRC = evc_pkg::SRC_PORT,
   parameter logic [STEP_W-1:0] UP_STEP     = STEP_W'(1),
   parameter evc_pkg::src_e     DN_STEP_SRC = evc_pkg::SRC_PORT,
   parameter logic [STEP_W-1:0] DN_STEP     = STEP_W'(1),
   parameter evc_pkg::src_e     UP_SAT      = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0]  UP_SAT_VAL  = '1,
   parameter evc_pkg::src_e     DN_SAT      = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0]  DN_SAT_VAL  = '0,
   parameter evc_pkg::src_e     THR_HI_SRC  = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0]  THR_HI_VAL  = '1,
   parameter evc_pkg::src_e     THR_LO_SRC  = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0]  THR_LO_VAL  = '0,
   parameter logic [CNT_W-1:0]  RST_VAL     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              incr,
   input  logic              decr,
   input  logic [STEP_W-1:0] incr_step,
   input  logic [STEP_W-1:0] decr_step,
   input  logic [CNT_W-1:0]  sat_hi_in,
   input  logic [CNT_W-1:0]  sat_lo_in,
   input  logic [CNT_W-1:0]  thr_hi_in,
   input  logic [CNT_W-1:0]  thr_lo_in,
   input  logic              sw_clr,
   input  logic              sw_we,
   input  logic [CNT_W-1:0]  sw_wdata,
   output logic [CNT_W-1:0]  count,
   output logic              thr_hi_flag,
   output logic              thr_lo_flag,
   output logic              overflow,
   output logic              underflow
);

   localparam bit UP_SAT_ON = (UP_SAT != evc_pkg::SRC_NONE);
   localparam bit DN_SAT_ON = (DN_SAT != evc_pkg::SRC_NONE);

   // elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("evt_counter: CNT_W must be at least 2");
      end
      if (STEP_W < 1 || STEP_W > CNT_W) begin : g_bad_step_w
         $error("evt_counter: STEP_W must lie in 1..CNT_W");
      end
      if (UP_EN && UP_STEP_SRC == evc_pkg::SRC_NONE) begin : g_bad_up_src
         $error("evt_counter: up step needs a fixed or port source");
      end
      if (DN_EN && DN_STEP_SRC == evc_pkg::SRC_NONE) begin : g_bad_dn_src
         $error("evt_counter: down step needs a fixed or port source");
      end
   endgenerate

   logic [STEP_W-1:0] up_step;
   logic [STEP_W-1:0] dn_step;
   logic [CNT_W-1:0]  lim_hi;
   logic [CNT_W-1:0]  lim_lo;
   logic [CNT_W-1:0]  thr_hi;
   logic [CNT_W-1:0]  thr_lo;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_d;

   evc_src_sel #(.W(STEP_W), .SRC(UP_STEP_SRC), .FIXED(UP_STEP), .DEFLT(STEP_W'(1)))
      u_up_step (.port_val(incr_step), .val(up_step));

   evc_src_sel #(.W(STEP_W), .SRC(DN_STEP_SRC), .FIXED(DN_STEP), .DEFLT(STEP_W'(1)))
      u_dn_step (.port_val(decr_step), .val(dn_step));

   evc_src_sel #(.W(CNT_W), .SRC(UP_SAT), .FIXED(UP_SAT_VAL), .DEFLT('1))
      u_lim_hi (.port_val(sat_hi_in), .val(lim_hi));

   evc_src_sel #(.W(CNT_W), .SRC(DN_SAT), .FIXED(DN_SAT_VAL), .DEFLT('0))
      u_lim_lo (.port_val(sat_lo_in), .val(lim_lo));

   evc_src_sel #(.W(CNT_W), .SRC(THR_HI_SRC), .FIXED(THR_HI_VAL), .DEFLT('1))
      u_thr_hi (.port_val(thr_hi_in), .val(thr_hi));

   evc_src_sel #(.W(CNT_W), .SRC(THR_LO_SRC), .FIXED(THR_LO_VAL), .DEFLT('0))
      u_thr_lo (.port_val(thr_lo_in), .val(thr_lo));

   evc_next #(
      .CNT_W    (CNT_W),
      .STEP_W   (STEP_W),
      .UP_EN    (UP_EN),
      .DN_EN    (DN_EN),
      .UP_SAT_ON(UP_SAT_ON),
      .DN_SAT_ON(DN_SAT_ON)
   ) u_next (
      .count   (cnt_q),
      .incr    (incr),
      .decr    (decr),
      .up_step (up_step),
      .dn_step (dn_step),
      .lim_hi  (lim_hi),
      .lim_lo  (lim_lo),
      .sw_clr  (sw_clr),
      .sw_we   (sw_we),
      .sw_wdata(sw_wdata),
      .nxt     (cnt_d),
      .ovf     (overflow),
      .udf     (underflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   evc_cmp #(.W(CNT_W), .AT_LEAST(1'b1))
      u_cmp_hi (.value(cnt_q), .limit(thr_hi), .hit(thr_hi_flag));

   evc_cmp #(.W(CNT_W), .AT_LEAST(1'b0))
      u_cmp_lo (.value(cnt_q), .limit(thr_lo), .hit(thr_lo_flag));

   assign count = cnt_q;

endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk #(
   parameter int               CNT_W      = 8,
   parameter evc_pkg::src_e    UP_SAT     = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0] UP_SAT_VAL = '1,
   parameter evc_pkg::src_e    DN_SAT     = evc_pkg::SRC_PORT,
   parameter logic [CNT_W-1:0] DN_SAT_VAL = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             incr,
   input logic             decr,
   input logic [CNT_W-1:0] sat_hi_in,
   input logic [CNT_W-1:0] sat_lo_in,
   input logic             sw_clr,
   input logic             sw_we,
   input logic [CNT_W-1:0] count,
   input logic             overflow,
   input logic             underflow
);

   localparam bit HI_ON = (UP_SAT != evc_pkg::SRC_NONE);
   localparam bit LO_ON = (DN_SAT != evc_pkg::SRC_NONE);

   logic [CNT_W-1:0] hi_v;
   logic [CNT_W-1:0] lo_v;
   logic [CNT_W-1:0] clr_exp;
   logic             idle;
   logic             in_range;

   assign hi_v     = (UP_SAT == evc_pkg::SRC_PORT) ? sat_hi_in :
                     (UP_SAT == evc_pkg::SRC_FIXED) ? UP_SAT_VAL : '1;
   assign lo_v     = (DN_SAT == evc_pkg::SRC_PORT) ? sat_lo_in :
                     (DN_SAT == evc_pkg::SRC_FIXED) ? DN_SAT_VAL : '0;
   assign clr_exp  = LO_ON ? lo_v : '0;
   assign idle     = !incr && !decr && !sw_clr && !sw_we;
   assign in_range = (!HI_ON || count <= hi_v) && (!LO_ON || count >= lo_v);

   // R8: a clear lands on zero, or on the lower bound when one is active
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> count == $past(clr_exp))
      else $error("R8 clear result wrong");

   // R7: an in-range count with no request holds
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && in_range) |=> count == $past(count))
      else $error("R7 idle count moved");

   // R11 / R12: the two wrap flags never coincide
   assert_one_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({overflow, underflow}))
      else $error("R11 overflow and underflow together");

   generate
      if (HI_ON) begin : g_hi
         assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !overflow)
            else $error("R5 overflow while saturating");
         assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!LO_ON || lo_v <= hi_v) |=> count <= $past(hi_v))
            else $error("R5 count above upper bound");
      end else begin : g_hi_wrap
         assert_ovf_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
            overflow |=> count < $past(count))
            else $error("R11 overflow without wrap");
      end

      if (LO_ON) begin : g_lo
         assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !underflow)
            else $error("R6 underflow while saturating");
         assert_sat_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> count >= $past(lo_v))
            else $error("R6 count below lower bound");
      end else begin : g_lo_wrap
         assert_udf_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
            underflow |=> count > $past(count))
            else $error("R12 underflow without wrap");
      end
   endgenerate

endmodule

bind evt_counter evc_counter_chk #(
   .CNT_W     (CNT_W),
   .UP_SAT    (UP_SAT),
   .UP_SAT_VAL(UP_SAT_VAL),
   .DN_SAT    (DN_SAT),
   .DN_SAT_VAL(DN_SAT_VAL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .incr     (incr),
   .decr     (decr),
   .sat_hi_in(sat_hi_in),
   .sat_lo_in(sat_lo_in),
   .sw_clr   (sw_clr),
   .sw_we    (sw_we),
   .count    (count),
   .overflow (overflow),
   .underflow(underflow)
);

// File: tb/tb_evt_counter.sv
`timescale 1ns/1ps
module tb_evt_counter;
   import evc_pkg::*;

   localparam int W   = 8;
   localparam int SW  = 4;
   localparam int MOD = 1 << W;
   localparam int B_UP = 3;
   localparam int B_DN = 2;
   localparam int B_TH = 200;
   localparam int B_TL = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          incr = 1'b0, decr = 1'b0, sw_clr = 1'b0, sw_we = 1'b0;
   logic [SW-1:0] incr_step = '0, decr_step = '0;
   logic [W-1:0]  sat_hi_in = '1, sat_lo_in = '0, thr_hi_in = '1, thr_lo_in = '0, sw_wdata = '0;

   logic [W-1:0]  cnt_a, cnt_b;
   logic          thh_a, thl_a, ov_a, un_a;
   logic          thh_b, thl_b, ov_b, un_b;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   int m_a = 0;
   int m_b = 0;

   always #10 clk = ~clk;

   evt_counter dut (
      .clk(clk), .rst_n(rst_n), .incr(incr), .decr(decr),
      .incr_step(incr_step), .decr_step(decr_step),
      .sat_hi_in(sat_hi_in), .sat_lo_in(sat_lo_in),
      .thr_hi_in(thr_hi_in), .thr_lo_in(thr_lo_in),
      .sw_clr(sw_clr), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .count(cnt_a), .thr_hi_flag(thh_a), .thr_lo_flag(thl_a),
      .overflow(ov_a), .underflow(un_a)
   );

   evt_counter #(
      .UP_STEP_SRC(SRC_FIXED), .UP_STEP(SW'(B_UP)),
      .DN_STEP_SRC(SRC_FIXED), .DN_STEP(SW'(B_DN)),
      .UP_SAT(SRC_NONE), .DN_SAT(SRC_NONE),
      .THR_HI_SRC(SRC_FIXED), .THR_HI_VAL(W'(B_TH)),
      .THR_LO_SRC(SRC_FIXED), .THR_LO_VAL(W'(B_TL))
   ) dut_w (
      .clk(clk), .rst_n(rst_n), .incr(incr), .decr(decr),
      .incr_step(incr_step), .decr_step(decr_step),
      .sat_hi_in(sat_hi_in), .sat_lo_in(sat_lo_in),
      .thr_hi_in(thr_hi_in), .thr_lo_in(thr_lo_in),
      .sw_clr(sw_clr), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .count(cnt_b), .thr_hi_flag(thh_b), .thr_lo_flag(thl_b),
      .overflow(ov_b), .underflow(un_b)
   );

   // next count from the requirements: priority, net step, clamp, wrap
   function automatic int model(int cur, bit inc, bit dec, int us, int ds,
                                bit hs, int hi, bit ls, int lo,
                                bit clr, bit we, int wd,
                                output bit ov, output bit un);
      int r;
      if (clr)     r = 0;
      else if (we) r = wd;
      else         r = cur + (inc ? us : 0) - (dec ? ds : 0);
      ov = !clr && !we && !hs && (r > MOD - 1);
      un = !clr && !we && !ls && (r < 0);
      if (hs && r > hi) r = hi;
      if (ls && r < lo) r = lo;
      return ((r % MOD) + MOD) % MOD;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic apply(string tag_a, string tag_b, bit inc, bit dec, int us, int ds,
                        int hi, int lo, int th, int tl, bit clr, bit we, int wd);
      bit ova, una, ovb, unb;
      int na, nb;
      @(negedge clk);
      incr = inc; decr = dec;
      incr_step = SW'(us); decr_step = SW'(ds);
      sat_hi_in = W'(hi); sat_lo_in = W'(lo);
      thr_hi_in = W'(th); thr_lo_in = W'(tl);
      sw_clr = clr; sw_we = we; sw_wdata = W'(wd);
      na = model(m_a, inc, dec, us, ds, 1'b1, hi, 1'b1, lo, clr, we, wd, ova, una);
      nb = model(m_b, inc, dec, B_UP, B_DN, 1'b0, 0, 1'b0, 0, clr, we, wd, ovb, unb);
      #2;
      chk("R9",  "dut thr_hi_flag", int'(thh_a), int'(m_a >= th));
      chk("R10", "dut thr_lo_flag", int'(thl_a), int'(m_a <= tl));
      chk("R5",  "dut overflow",    int'(ov_a),  int'(ova));
      chk("R6",  "dut underflow",   int'(un_a),  int'(una));
      chk("R13", "wrap thr_hi_flag", int'(thh_b), int'(m_b >= B_TH));
      chk("R13", "wrap thr_lo_flag", int'(thl_b), int'(m_b <= B_TL));
      chk("R11", "wrap overflow",   int'(ov_b),  int'(ovb));
      chk("R12", "wrap underflow",  int'(un_b),  int'(unb));
      @(posedge clk);
      #2;
      chk(tag_a, "dut count",  int'(cnt_a), na);
      chk(tag_b, "wrap count", int'(cnt_b), nb);
      m_a = na;
      m_b = nb;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: all requirements actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int hi, lo, th, tl, us, ds, wd;
      bit inc, dec, clr, we;
      string tag;
      void'($urandom(32'd7311));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1", "dut count after reset",  int'(cnt_a), 0);
      chk("R1", "wrap count after reset", int'(cnt_b), 0);

      // directed corners, bounds 5..100
      apply("R7", "R13", 0, 0, 0, 0, 100, 5, 50, 20, 0, 0, 0);   // 0 pulled up to 5
      apply("R2", "R13", 1, 0, 7, 0, 100, 5, 50, 20, 0, 0, 0);
      apply("R3", "R13", 0, 1, 0, 3, 100, 5, 50, 20, 0, 0, 0);
      apply("R4", "R4",  1, 1, 7, 3, 100, 5, 50, 20, 0, 0, 0);
      apply("R8", "R8",  0, 0, 0, 0, 100, 5, 50, 20, 0, 1, 98);
      apply("R5", "R13", 1, 0, 2, 0, 100, 5, 50, 20, 0, 0, 0);   // lands on bound
      apply("R5", "R13", 1, 0, 15, 0, 100, 5, 50, 20, 0, 0, 0);  // held at bound
      apply("R8", "R8",  0, 0, 0, 0, 100, 5, 50, 20, 0, 1, 7);
      apply("R6", "R13", 0, 1, 0, 2, 100, 5, 50, 20, 0, 0, 0);   // lands on bound
      apply("R6", "R13", 0, 1, 0, 9, 100, 5, 50, 20, 0, 0, 0);   // held at bound
      apply("R7", "R8",  0, 0, 0, 0, 100, 5, 50, 20, 0, 1, 200); // write clamped
      apply("R8", "R8",  1, 0, 4, 0, 100, 5, 50, 20, 1, 0, 0);   // clear beats incr
      apply("R8", "R8",  0, 0, 0, 0, 100, 5, 50, 20, 1, 1, 60);  // clear beats write
      apply("R8", "R8",  1, 1, 9, 1, 100, 5, 50, 20, 0, 1, 60);  // write beats count
      apply("R7", "R13", 0, 0, 0, 0, 20, 30, 50, 20, 0, 0, 0);   // inverted bounds
      apply("R9", "R10", 0, 0, 0, 0, 255, 0, 30, 30, 0, 0, 0);
      apply("R8", "R8",  0, 0, 0, 0, 255, 0, 30, 30, 0, 1, 254);
      apply("R5", "R11", 1, 0, 15, 0, 255, 0, 255, 0, 0, 0, 0); // wrap instance 254 -> 1
      apply("R8", "R8",  0, 0, 0, 0, 255, 0, 255, 0, 0, 1, 1);
      apply("R6", "R12", 0, 1, 0, 4, 255, 0, 255, 0, 0, 0, 0);  // wrap instance 1 -> 255
      apply("R4", "R11", 1, 1, 15, 1, 255, 0, 200, 10, 0, 0, 0);

      hi = 255; lo = 0; th = 128; tl = 64;
      for (int i = 0; i < 3000; i++) begin
         if (i % 16 == 0) begin
            hi = $urandom_range(0, 255);
            lo = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                              : int'($urandom_range(0, hi));
            th = $urandom_range(0, 255);
            tl = $urandom_range(0, 255);
         end
         inc = 1'($urandom_range(0, 1));
         dec = 1'($urandom_range(0, 1));
         us  = $urandom_range(0, 15);
         ds  = $urandom_range(0, 15);
         clr = ($urandom_range(0, 31) == 0);
         we  = ($urandom_range(0, 19) == 0);
         wd  = $urandom_range(0, 255);
         if (clr || we)       tag = "R8";
         else if (inc && dec) tag = "R4";
         else if (inc)        tag = "R2";
         else if (dec)        tag = "R3";
         else                 tag = "R7";
         apply(tag, "R13", inc, dec, us, ds, hi, lo, th, tl, clr, we, wd);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule